// File: doc/BRIEF.md
# ALU with Two-Level Operation Decoder

This block pairs a 32-bit arithmetic/logic unit with the small local decoder that drives it. The main control of a processor hands the block a 2-bit operation class, and the block looks at four function bits taken from the instruction word. From these it forms a 4-bit operation code. The ALU applies that operation to two operands and reports the result together with a flag that is high when the result is zero. Equality branches use that flag.

Only four operations exist: bitwise AND, bitwise OR, addition and subtraction. The address class always adds. The branch class always subtracts. The function class chooses among the four from the function bits. The block has no clock and no storage. The outputs follow the inputs within the same cycle.

Top module: `aluTwoLevel`

## Requirements
- R1: `aluCode` only ever takes one of four values: 4'b0000 for AND, 4'b0001 for OR, 4'b0010 for add and 4'b0110 for subtract.
- R2: When `opClass` is 2'b00, the code is add (4'b0010) and `result` is opA+opB, whatever `fnAlt` and `fnSel` are.
- R3: When `opClass` is 2'b01, the code is subtract (4'b0110) and `result` is opA-opB, whatever `fnAlt` and `fnSel` are.
- R4: When `opClass` is 2'b10 and `fnSel` is 3'b000, `fnAlt`=0 gives add and `fnAlt`=1 gives subtract.
- R5: When `opClass` is 2'b10, `fnSel`=3'b111 gives AND and `fnSel`=3'b110 gives OR, whatever `fnAlt` is.
- R6: When `opClass` is 2'b10 and `fnSel` is any other value (001 to 101), the block adds.
- R7: Only the high class bit selects function decoding, so `opClass`=2'b11 behaves exactly like 2'b10.
- R8: Addition and subtraction wrap modulo 2^32 and give no overflow indication.
- R9: `zero` is 1 exactly when all 32 bits of `result` are 0. Subtracting equal operands therefore raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opClass | input | 2 | Operation class from main control: 00 address, 01 branch, 10 function |
| fnAlt | input | 1 | Alternate-operation bit from the instruction (bit 30) |
| fnSel | input | 3 | Function-select field from the instruction (bits 14:12) |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| aluCode | output | 4 | Decoded 4-bit operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The embedded checks assume that the class and function inputs carry known values. Each check is skipped while any of those inputs is X or Z. The class code 11 is outside what the main control produces, but the checks do not exclude it, because the decoder has a defined answer for it.

The stimulus drives every class and function combination, all 64 of them, from a held, defined state. Each combination is paired with operand sets chosen to hit carry-out, borrow-through-zero, equal operands and sign-bit-only values. This places the zero flag and the wrap behaviour at their edges.

// File: rtl/aluTwoLevelPkg.sv
package aluTwoLevelPkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SUB = 4'b0110
  } aluCodeE;

  localparam logic [2:0] FN_ADDSUB = 3'b000;
  localparam logic [2:0] FN_AND    = 3'b111;
  localparam logic [2:0] FN_OR     = 3'b110;

  typedef struct packed {
    logic selAnd;
    logic selOr;
    logic invertB;
  } aluStrobesT;

endpackage

// File: rtl/aluCtrlDecode.sv
module aluCtrlDecode
  import aluTwoLevelPkg::*;
(
  input  logic [1:0] opClass,
  input  logic       fnAlt,
  input  logic [2:0] fnSel,
  output logic [3:0] aluCode,
  output aluStrobesT strobes
);

  aluCodeE codeSel;

  // First level: class. The high bit wins, so class 11 falls into function decoding.
  always_comb begin
    if (opClass[1]) begin
      unique case (fnSel)
        FN_ADDSUB: codeSel = fnAlt ? OP_SUB : OP_ADD;
        FN_AND:    codeSel = OP_AND;
        FN_OR:     codeSel = OP_OR;
        default:   codeSel = OP_ADD;
      endcase
    end else if (opClass[0]) begin
      codeSel = OP_SUB;
    end else begin
      codeSel = OP_ADD;
    end
  end

  assign aluCode = codeSel;

  // Second level: turn the code into datapath strobes.
  always_comb begin
    strobes.selAnd  = (codeSel == OP_AND);
    strobes.selOr   = (codeSel == OP_OR);
    strobes.invertB = (codeSel == OP_SUB);
  end

  always_comb begin
    if (!$isunknown({opClass, fnAlt, fnSel})) begin
      p_code_legal_r1: assert (aluCode == 4'b0000 || aluCode == 4'b0001 ||
                               aluCode == 4'b0010 || aluCode == 4'b0110)
        else $error("illegal aluCode %b", aluCode);
      if (opClass == 2'b00)
        p_addr_add_r2: assert (aluCode == 4'b0010) else $error("class 00 not add");
      if (opClass == 2'b01)
        p_branch_sub_r3: assert (aluCode == 4'b0110) else $error("class 01 not sub");
      if (opClass[1] && (fnSel == 3'b111 || fnSel == 3'b110))
        p_logic_pick_r5: assert (aluCode[3:1] == 3'b000) else $error("logic op not chosen");
      if (opClass[1] && fnSel != 3'b000 && fnSel != 3'b111 && fnSel != 3'b110)
        p_default_add_r6: assert (aluCode == 4'b0010) else $error("default not add");
      p_strobe_excl_r1: assert ($onehot0({strobes.selAnd, strobes.selOr, strobes.invertB}))
        else $error("strobes overlap");
    end
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluTwoLevelPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluStrobesT        strobes,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  output logic [WIDTH-1:0]  result,
  output logic              zero
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] operandB;
  logic [WIDTH-1:0] sumOut;

  // Subtract reuses the adder: a + ~b + 1; the carry out is dropped.
  assign operandB = strobes.invertB ? ~opB : opB;
  assign sumOut   = opA + operandB + {{(WIDTH-1){1'b0}}, strobes.invertB};

  always_comb begin
    if (strobes.selAnd)     result = opA & opB;
    else if (strobes.selOr) result = opA | opB;
    else                    result = sumOut;
  end

  assign zero = ~|result;

  always_comb begin
    if (!$isunknown({strobes, opA, opB})) begin
      if (strobes.invertB && opA == opB)
        p_equal_zero_r9: assert (zero) else $error("equal operands gave nonzero");
      if (strobes.invertB && opA == '0 && opB == {{(WIDTH-1){1'b0}}, 1'b1})
        p_sub_wrap_r8: assert (result == ALL_ONES) else $error("sub did not wrap");
      if (!strobes.selAnd && !strobes.selOr && !strobes.invertB && opA == ALL_ONES &&
          opB == {{(WIDTH-1){1'b0}}, 1'b1})
        p_add_wrap_r8: assert (result == '0) else $error("add did not wrap");
      if (strobes.selAnd && (opA == '0 || opB == '0))
        p_and_zero_r9: assert (zero) else $error("and with zero not flagged");
    end
  end

endmodule

// File: rtl/aluTwoLevel.sv
module aluTwoLevel
  import aluTwoLevelPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       opClass,
  input  logic             fnAlt,
  input  logic [2:0]       fnSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [3:0]       aluCode,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  aluStrobesT ctrlStrobes;

  aluCtrlDecode i_decode (
    .opClass (opClass),
    .fnAlt   (fnAlt),
    .fnSel   (fnSel),
    .aluCode (aluCode),
    .strobes (ctrlStrobes)
  );

  aluDatapath #(.WIDTH(WIDTH)) i_datapath (
    .strobes (ctrlStrobes),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .zero    (zero)
  );

endmodule

// File: tb/test_aluTwoLevel.sv
module test_aluTwoLevel;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    logic [3:0]  code;
    logic [31:0] res;
    logic        zf;
    string       tag;
    string       resTag;
  } expItemT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  opClass = 2'b00;
  logic        fnAlt = 1'b0;
  logic [2:0]  fnSel = 3'b000;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  aluCode;
  logic [31:0] result;
  logic        zero;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit driverDone = 1'b0;
  expItemT expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  aluTwoLevel i_aluTwoLevel (
    .opClass(opClass), .fnAlt(fnAlt), .fnSel(fnSel),
    .opA(opA), .opB(opB),
    .aluCode(aluCode), .result(result), .zero(zero)
  );

  // Reference model taken from the requirement text.
  function automatic logic [3:0] refCode(input logic [1:0] c, input logic alt, input logic [2:0] f);
    if (c == 2'b00) return 4'b0010;            // R2
    if (c == 2'b01) return 4'b0110;            // R3
    if (f == 3'b000) return alt ? 4'b0110 : 4'b0010;  // R4, R7
    if (f == 3'b111) return 4'b0000;           // R5
    if (f == 3'b110) return 4'b0001;           // R5
    return 4'b0010;                            // R6
  endfunction

  function automatic string refTag(input logic [1:0] c, input logic [2:0] f);
    if (c == 2'b00) return "R2";
    if (c == 2'b01) return "R3";
    if (c == 2'b11) return "R7";
    if (f == 3'b000) return "R4";
    if (f == 3'b111 || f == 3'b110) return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] c, input logic alt, input logic [2:0] f,
                       input logic [31:0] a, input logic [31:0] b, input bit wrapCase);
    expItemT it;
    @(posedge clk);
    opClass = c; fnAlt = alt; fnSel = f; opA = a; opB = b;
    it.code = refCode(c, alt, f);
    case (it.code)
      4'b0000: it.res = a & b;
      4'b0001: it.res = a | b;
      4'b0110: it.res = a - b;
      default: it.res = a + b;
    endcase
    it.zf = (it.res == 32'h0);
    it.tag = refTag(c, f);
    it.resTag = wrapCase ? "R8" : it.tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares one item per cycle, mid-period.
  always @(negedge clk) begin
    if (!rst && expQ.size() > 0) begin
      expItemT it;
      it = expQ.pop_front();
      check({"R1/", it.tag}, "aluCode", {28'h0, aluCode}, {28'h0, it.code});
      check(it.resTag, "result", result, it.res);
      check("R9", "zero", {31'h0, zero}, {31'h0, it.zf});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      total++; bad++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: held inputs are all zero, class 00 adds 0+0.
    check("R2", "reset aluCode", {28'h0, aluCode}, 32'h2);
    check("R9", "reset zero", {31'h0, zero}, 32'h1);
    rst = 1'b0;

    for (int c = 0; c < 4; c++) begin
      for (int fv = 0; fv < 16; fv++) begin
        for (int k = 0; k < 6; k++) begin
          logic [31:0] a, b;
          bit w;
          w = 1'b0;
          case (k)
            0: begin a = 32'd5;        b = 32'd3; end
            1: begin a = 32'hFFFF_FFFF; b = 32'd1; w = 1'b1; end
            2: begin a = 32'd0;        b = 32'd1; w = 1'b1; end
            3: begin a = 32'h1234_5678; b = 32'h1234_5678; end
            4: begin a = 32'hF0F0_F0F0; b = 32'h0FF0_0FF0; end
            default: begin a = 32'h8000_0000; b = 32'h8000_0000; w = 1'b1; end
          endcase
          drive(c[1:0], fv[3], fv[2:0], a, b, w);
        end
      end
    end
    @(posedge clk);
    @(posedge clk);
    driverDone = 1'b1;
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL R1 queue not drained actual=%0d expected=0", expQ.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule